// File: doc/BRIEF.md
# Indirect-Branch Virtual-Target Training Sequencer

When an indirect branch commits, this block walks the same chain of virtual branch identities that the prediction logic used at fetch time. It then issues the training commands for the shared target buffer and the conditional direction predictor. Both storage structures sit outside the block. For every step the block forms a virtual PC and a virtual history. It drives at most one virtual branch's worth of commands per cycle: a target-buffer lookup, a direction update, a replacement touch, or an insert of a new target.

A correct prediction replays steps 1 up to the predicted step. This walk reads nothing from the target buffer. Every earlier step is trained not-taken, and the final step is trained taken and touched. A wrong prediction looks up every step until one holds the correct target, and that step is trained taken and touched. If no step holds the correct target, the block spends one extra cycle writing the correct target into a chosen slot.

Top module: `vbr_train_seq`

## Requirements
- R1: After reset, `busy` and `done` are low and every command enable is low. While `busy` is low, no command enable or `done` is ever high.
- R2: Step k uses the virtual PC `pc ^ ((k-1) * 0x9E3779B1)`, truncated to the PC width, and the virtual history `ghr << (k-1)`. Step 1 therefore uses the PC and history unchanged.
- R3: A request is taken while idle. Step 1 is driven in the next cycle, and each later cycle drives the next step. `busy` stays high from that cycle through the cycle in which `done` pulses, and it is low in the cycle after.
- R4: In a correct-prediction walk with predicted step P, steps 1..P each issue a direction update with no target-buffer read. Steps below P are updated not-taken. Step P is updated taken and touched, and `done` pulses in that cycle.
- R5: In a wrong-prediction walk, every step issues a read. The first step that hits with a target equal to the correct target is updated taken and touched, with `done`, and the walk ends there.
- R6: In a wrong-prediction walk, a step that hits with a different target is updated not-taken. A step that misses issues no direction update.
- R7: If no step up to MAX_ITER matches, one extra cycle follows. It issues an insert of the correct target and a taken direction update, and pulses `done`. This command uses the PC and history of the earliest step that missed.
- R8: If every step hit with a wrong target, the insert uses the step with the lowest usage count. On a tie in usage count, the later step wins.
- R9: A request presented while `busy` is high is ignored, and it starts no further walk.
- R10: A request flagged correct whose predicted step is 0 or above MAX_ITER is handled as a wrong prediction.
- R11: A touch and an insert are never issued in the same cycle. All commands in a cycle carry the same virtual PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Commit training request |
| req_pc | input | PC_W | PC of the committed indirect branch |
| req_ghr | input | GHR_W | Global history captured at fetch |
| req_target | input | PC_W | Resolved correct target |
| req_correct | input | 1 | Prediction was correct |
| req_iter | input | ITER_W | Predicted step number (1-based) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Final command of the walk this cycle |
| btb_rd_en | output | 1 | Target-buffer lookup |
| btb_rd_vpc | output | PC_W | Lookup virtual PC |
| btb_rd_hit | input | 1 | Lookup hit (same cycle) |
| btb_rd_tgt | input | PC_W | Target held by the hit entry |
| btb_rd_use | input | USE_W | Usage count of the hit entry |
| dir_upd_en | output | 1 | Direction predictor update |
| dir_upd_taken | output | 1 | Update outcome (1 = taken) |
| dir_upd_vpc | output | PC_W | Update virtual PC |
| dir_upd_ghr | output | GHR_W | Update virtual history |
| btb_touch_en | output | 1 | Replacement-state touch |
| btb_ins_en | output | 1 | Insert the correct target |
| btb_wr_vpc | output | PC_W | Virtual PC for touch or insert |
| btb_ins_tgt | output | PC_W | Target to insert |

## Verification
The assertions check several behaviours on every cycle. The block stays quiet while idle, and `busy` ends right after `done`. A correct walk never reads the target buffer. A miss never causes a direction update, and a matching hit always ends the walk with a taken update and a touch. An insert always comes with a taken update, and a touch and an insert never occur together. Only the bench's scenarios can show that the hashed virtual PC and shifted history are right for each step, and that the step chosen for an insert follows the earliest-miss and lowest-usage rules with later-wins ties. The scenarios also show that out-of-range predicted steps fall back to the wrong-prediction walk, and that a request presented while busy is ignored.

// File: rtl/vbr_train_pkg.sv
package vbr_train_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_INS  = 2'd2
  } vbr_state_e;

  // Salt mixed into the PC for step k (1-based); step 1 gets zero.
  function automatic logic [63:0] vbr_salt(input logic [31:0] k);
    logic [63:0] km1;
    km1 = (k == 32'd0) ? 64'd0 : 64'(k - 32'd1);
    return km1 * 64'h0000_0000_9E37_79B1;
  endfunction

endpackage

// File: rtl/vbr_hash.sv
module vbr_hash #(
  parameter int PC_W   = 32,
  parameter int GHR_W  = 16,
  parameter int ITER_W = 3
) (
  input  logic [PC_W-1:0]   base_pc,
  input  logic [GHR_W-1:0]  base_ghr,
  input  logic [ITER_W-1:0] iter,
  output logic [PC_W-1:0]   vpc,
  output logic [GHR_W-1:0]  vghr
);
  import vbr_train_pkg::*;

  logic [63:0] salt;

  always_comb begin
    salt = vbr_salt(32'(iter));
    vpc  = base_pc ^ salt[PC_W-1:0];
    vghr = (iter == '0) ? base_ghr : (base_ghr << (iter - 1'b1));
  end

endmodule

// File: rtl/vbr_victim.sv
module vbr_victim #(
  parameter int ITER_W = 3,
  parameter int USE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              is_miss,
  input  logic              is_mism,
  input  logic [USE_W-1:0]  use_cnt,
  input  logic [ITER_W-1:0] iter,
  output logic [ITER_W-1:0] pick_iter
);

  logic              miss_seen, miss_seen_n;
  logic [ITER_W-1:0] miss_it,   miss_it_n;
  logic              lfu_seen,  lfu_seen_n;
  logic [ITER_W-1:0] lfu_it,    lfu_it_n;
  logic [USE_W-1:0]  lfu_use,   lfu_use_n;

  always_comb begin
    miss_seen_n = miss_seen;
    miss_it_n   = miss_it;
    lfu_seen_n  = lfu_seen;
    lfu_it_n    = lfu_it;
    lfu_use_n   = lfu_use;
    if (clear) begin
      miss_seen_n = 1'b0;
      miss_it_n   = '0;
      lfu_seen_n  = 1'b0;
      lfu_it_n    = '0;
      lfu_use_n   = '0;
    end else if (sample) begin
      if (is_miss && !miss_seen) begin
        miss_seen_n = 1'b1;
        miss_it_n   = iter;
      end
      if (is_mism && (!lfu_seen || use_cnt <= lfu_use)) begin
        lfu_seen_n = 1'b1;
        lfu_it_n   = iter;
        lfu_use_n  = use_cnt;
      end
    end
    pick_iter = miss_seen_n ? miss_it_n : lfu_it_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_seen <= 1'b0;
      miss_it   <= '0;
      lfu_seen  <= 1'b0;
      lfu_it    <= '0;
      lfu_use   <= '0;
    end else begin
      miss_seen <= miss_seen_n;
      miss_it   <= miss_it_n;
      lfu_seen  <= lfu_seen_n;
      lfu_it    <= lfu_it_n;
      lfu_use   <= lfu_use_n;
    end
  end

  // R7: once a miss is recorded it is kept until the next clear
  a_r7_miss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    miss_seen && !clear |=> miss_seen && $stable(miss_it));

endmodule

// File: rtl/vbr_train_seq.sv
module vbr_train_seq #(
  parameter int PC_W     = 32,
  parameter int GHR_W    = 16,
  parameter int MAX_ITER = 4,
  parameter int USE_W    = 3,
  localparam int ITER_W  = $clog2(MAX_ITER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [GHR_W-1:0]  req_ghr,
  input  logic [PC_W-1:0]   req_target,
  input  logic              req_correct,
  input  logic [ITER_W-1:0] req_iter,
  output logic              busy,
  output logic              done,
  output logic              btb_rd_en,
  output logic [PC_W-1:0]   btb_rd_vpc,
  input  logic              btb_rd_hit,
  input  logic [PC_W-1:0]   btb_rd_tgt,
  input  logic [USE_W-1:0]  btb_rd_use,
  output logic              dir_upd_en,
  output logic              dir_upd_taken,
  output logic [PC_W-1:0]   dir_upd_vpc,
  output logic [GHR_W-1:0]  dir_upd_ghr,
  output logic              btb_touch_en,
  output logic              btb_ins_en,
  output logic [PC_W-1:0]   btb_wr_vpc,
  output logic [PC_W-1:0]   btb_ins_tgt
);
  import vbr_train_pkg::*;

  localparam logic [ITER_W-1:0] LAST = ITER_W'(MAX_ITER);

  vbr_state_e        state;
  logic [PC_W-1:0]   base_pc, base_tgt;
  logic [GHR_W-1:0]  base_ghr;
  logic              mode_ok;
  logic [ITER_W-1:0] pred_iter, iter;

  logic [PC_W-1:0]   cur_vpc;
  logic [GHR_W-1:0]  cur_ghr;
  logic [ITER_W-1:0] pick_iter;

  // named internal events
  logic accept, walk_rd, step_match, step_mism, step_miss, corr_fin, ins_step;

  vbr_hash #(.PC_W(PC_W), .GHR_W(GHR_W), .ITER_W(ITER_W)) hash_i (
    .base_pc(base_pc), .base_ghr(base_ghr), .iter(iter),
    .vpc(cur_vpc), .vghr(cur_ghr)
  );

  vbr_victim #(.ITER_W(ITER_W), .USE_W(USE_W)) victim_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(walk_rd),
    .is_miss(step_miss), .is_mism(step_mism), .use_cnt(btb_rd_use),
    .iter(iter), .pick_iter(pick_iter)
  );

  always_comb begin
    accept     = (state == ST_IDLE) && req_valid;
    walk_rd    = (state == ST_WALK) && !mode_ok;
    step_match = walk_rd && btb_rd_hit && (btb_rd_tgt == base_tgt);
    step_mism  = walk_rd && btb_rd_hit && (btb_rd_tgt != base_tgt);
    step_miss  = walk_rd && !btb_rd_hit;
    corr_fin   = (state == ST_WALK) && mode_ok && (iter == pred_iter);
    ins_step   = (state == ST_INS);

    busy          = (state != ST_IDLE);
    done          = corr_fin || step_match || ins_step;
    btb_rd_en     = walk_rd;
    btb_rd_vpc    = cur_vpc;
    dir_upd_en    = ((state == ST_WALK) && mode_ok) || step_match || step_mism || ins_step;
    dir_upd_taken = corr_fin || step_match || ins_step;
    dir_upd_vpc   = cur_vpc;
    dir_upd_ghr   = cur_ghr;
    btb_touch_en  = corr_fin || step_match;
    btb_ins_en    = ins_step;
    btb_wr_vpc    = cur_vpc;
    btb_ins_tgt   = base_tgt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      base_pc   <= '0;
      base_ghr  <= '0;
      base_tgt  <= '0;
      mode_ok   <= 1'b0;
      pred_iter <= '0;
      iter      <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          state     <= ST_WALK;
          base_pc   <= req_pc;
          base_ghr  <= req_ghr;
          base_tgt  <= req_target;
          mode_ok   <= req_correct && (req_iter != '0) && (req_iter <= LAST);
          pred_iter <= req_iter;
          iter      <= ITER_W'(1);
        end
        ST_WALK: begin
          if (done)                      state <= ST_IDLE;
          else if (!mode_ok && iter == LAST) begin
            state <= ST_INS;
            iter  <= pick_iter;
          end else                       iter  <= iter + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: quiet while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(btb_rd_en || dir_upd_en || btb_touch_en || btb_ins_en || done));
  // R3: walk ends the cycle after done
  a_r3_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R3: busy persists until done
  a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  // R4: correct walk never reads the target buffer
  a_r4_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mode_ok |-> !btb_rd_en);
  // R5: a matching hit ends the walk with taken + touch
  a_r5_match_ends: assert property (@(posedge clk) disable iff (!rst_n)
    btb_rd_en && btb_rd_hit && (btb_rd_tgt == btb_ins_tgt) |-> dir_upd_taken && btb_touch_en && done);
  // R6: a miss gives no direction update
  a_r6_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    btb_rd_en && !btb_rd_hit |-> !dir_upd_en);
  // R7: insert comes with a taken update and done
  a_r7_ins_taken: assert property (@(posedge clk) disable iff (!rst_n)
    btb_ins_en |-> dir_upd_en && dir_upd_taken && done);
  // R9: latched request stays fixed through the walk
  a_r9_latched: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(base_pc) && $stable(base_tgt));
  // R11: touch and insert are exclusive
  a_r11_one_branch: assert property (@(posedge clk) disable iff (!rst_n)
    !(btb_touch_en && btb_ins_en));

endmodule

// File: tb/vbr_train_seq_tb_top.sv
module vbr_train_seq_tb_top;

  localparam int PC_W = 32, GHR_W = 16, MAX_ITER = 4, USE_W = 3, ITER_W = 3;

  typedef struct packed {
    logic rd, dir, tk, touch, ins, dn;
    logic [31:0] vpc;
    logic [15:0] ghr;
    logic [31:0] tgt;
    logic [7:0]  rq;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              req_valid = 1'b0, req_correct = 1'b0;
  logic [31:0]       req_pc = '0, req_target = '0;
  logic [15:0]       req_ghr = '0;
  logic [ITER_W-1:0] req_iter = '0;
  logic busy, done, btb_rd_en, btb_rd_hit, dir_upd_en, dir_upd_taken, btb_touch_en, btb_ins_en;
  logic [31:0] btb_rd_vpc, btb_rd_tgt, dir_upd_vpc, btb_wr_vpc, btb_ins_tgt;
  logic [15:0] dir_upd_ghr;
  logic [USE_W-1:0] btb_rd_use;

  vbr_train_seq #(.PC_W(PC_W), .GHR_W(GHR_W), .MAX_ITER(MAX_ITER), .USE_W(USE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc), .req_ghr(req_ghr),
    .req_target(req_target), .req_correct(req_correct), .req_iter(req_iter),
    .busy(busy), .done(done), .btb_rd_en(btb_rd_en), .btb_rd_vpc(btb_rd_vpc),
    .btb_rd_hit(btb_rd_hit), .btb_rd_tgt(btb_rd_tgt), .btb_rd_use(btb_rd_use),
    .dir_upd_en(dir_upd_en), .dir_upd_taken(dir_upd_taken), .dir_upd_vpc(dir_upd_vpc),
    .dir_upd_ghr(dir_upd_ghr), .btb_touch_en(btb_touch_en), .btb_ins_en(btb_ins_en),
    .btb_wr_vpc(btb_wr_vpc), .btb_ins_tgt(btb_ins_tgt)
  );

  // target-buffer model
  logic             m_vld [8];
  logic [31:0]      m_vpc [8];
  logic [31:0]      m_tgt [8];
  logic [USE_W-1:0] m_use [8];

  always_comb begin
    btb_rd_hit = 1'b0;
    btb_rd_tgt = '0;
    btb_rd_use = '0;
    for (int i = 0; i < 8; i++)
      if (m_vld[i] && m_vpc[i] == btb_rd_vpc) begin
        btb_rd_hit = 1'b1;
        btb_rd_tgt = m_tgt[i];
        btb_rd_use = m_use[i];
      end
  end

  int checks = 0, failures = 0;
  exp_t q[$];

  function automatic logic [31:0] vpc_of(logic [31:0] pc, int k);
    logic [31:0] s = '0;
    for (int j = 1; j < k; j++) s = s + 32'h9E37_79B1;
    return pc ^ s;
  endfunction

  function automatic logic [15:0] ghr_of(logic [15:0] g, int k);
    logic [15:0] r = g;
    for (int j = 1; j < k; j++) r = {r[14:0], 1'b0};
    return r;
  endfunction

  task automatic clear_btb();
    for (int i = 0; i < 8; i++) begin
      m_vld[i] = 1'b0; m_vpc[i] = '0; m_tgt[i] = '0; m_use[i] = '0;
    end
  endtask

  task automatic put(int idx, logic [31:0] vpc, logic [31:0] tgt, int u);
    m_vld[idx] = 1'b1; m_vpc[idx] = vpc; m_tgt[idx] = tgt; m_use[idx] = USE_W'(u);
  endtask

  function automatic void model_lookup(logic [31:0] vpc, output logic hit,
                                       output logic [31:0] tgt, output int u);
    hit = 1'b0; tgt = '0; u = 0;
    for (int i = 0; i < 8; i++)
      if (m_vld[i] && m_vpc[i] == vpc) begin hit = 1'b1; tgt = m_tgt[i]; u = int'(m_use[i]); end
  endfunction

  // driver: builds the expected command stream, then presents the request
  task automatic run_commit(logic [31:0] pc, logic [15:0] ghr, logic [31:0] tgt,
                            logic corr, int piter, int rq, int junk_cycles);
    exp_t e;
    bit ok = corr && piter >= 1 && piter <= MAX_ITER;
    if (ok) begin
      for (int k = 1; k <= piter; k++) begin
        e = '0; e.rq = 8'(rq);
        e.dir = 1'b1; e.tk = (k == piter); e.touch = (k == piter); e.dn = (k == piter);
        e.vpc = vpc_of(pc, k); e.ghr = ghr_of(ghr, k); e.tgt = tgt;
        q.push_back(e);
      end
    end else begin
      bit found = 0, miss_seen = 0, lfu_seen = 0;
      int miss_k = 0, lfu_k = 0, lfu_u = 0, pick;
      for (int k = 1; k <= MAX_ITER && !found; k++) begin
        logic h; logic [31:0] t; int u;
        model_lookup(vpc_of(pc, k), h, t, u);
        e = '0; e.rq = 8'(rq); e.rd = 1'b1;
        e.vpc = vpc_of(pc, k); e.ghr = ghr_of(ghr, k); e.tgt = tgt;
        if (h && t == tgt) begin
          e.dir = 1'b1; e.tk = 1'b1; e.touch = 1'b1; e.dn = 1'b1; found = 1;
        end else if (h) begin
          e.dir = 1'b1;
          if (!lfu_seen || u <= lfu_u) begin lfu_seen = 1; lfu_k = k; lfu_u = u; end
        end else if (!miss_seen) begin
          miss_seen = 1; miss_k = k;
        end
        q.push_back(e);
      end
      if (!found) begin
        pick = miss_seen ? miss_k : lfu_k;
        e = '0; e.rq = 8'(rq); e.ins = 1'b1; e.dir = 1'b1; e.tk = 1'b1; e.dn = 1'b1;
        e.vpc = vpc_of(pc, pick); e.ghr = ghr_of(ghr, pick); e.tgt = tgt;
        q.push_back(e);
      end
    end
    @(negedge clk);
    req_pc = pc; req_ghr = ghr; req_target = tgt; req_correct = corr;
    req_iter = ITER_W'(piter); req_valid = 1'b1;
    @(negedge clk);
    for (int j = 0; j < junk_cycles; j++) begin
      req_pc = pc ^ 32'h0F0F_0000; req_target = tgt ^ 32'h1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (q.size() != 0 || busy) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compares each busy cycle against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        checks++;
        if (q.size() == 0) begin
          failures++;
          $display("FAIL R9 unexpected walk cycle: actual busy=1 expected idle");
        end else begin
          exp_t e;
          bit bad;
          e = q.pop_front();
          bad = (btb_rd_en != e.rd) || (dir_upd_en != e.dir) || (btb_touch_en != e.touch) ||
                (btb_ins_en != e.ins) || (done != e.dn) ||
                (e.dir && (dir_upd_taken != e.tk || dir_upd_vpc != e.vpc || dir_upd_ghr != e.ghr)) ||
                (e.rd && btb_rd_vpc != e.vpc) ||
                ((e.touch || e.ins) && btb_wr_vpc != e.vpc) ||
                (e.ins && btb_ins_tgt != e.tgt);
          if (bad) begin
            failures++;
            $display("FAIL R%0d actual rd=%b dir=%b tk=%b touch=%b ins=%b done=%b vpc=%h ghr=%h wr=%h tgt=%h expected rd=%b dir=%b tk=%b touch=%b ins=%b done=%b vpc=%h ghr=%h tgt=%h",
                     e.rq, btb_rd_en, dir_upd_en, dir_upd_taken, btb_touch_en, btb_ins_en, done,
                     (btb_rd_en ? btb_rd_vpc : dir_upd_vpc), dir_upd_ghr, btb_wr_vpc, btb_ins_tgt,
                     e.rd, e.dir, e.tk, e.touch, e.ins, e.dn, e.vpc, e.ghr, e.tgt);
          end
          if (btb_touch_en && btb_ins_en) begin
            failures++;
            $display("FAIL R11 actual touch=1 ins=1 expected exclusive");
          end
        end
      end else if (btb_rd_en || dir_upd_en || btb_touch_en || btb_ins_en || done) begin
        checks++; failures++;
        $display("FAIL R1 idle activity: actual cmd while idle expected none");
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [31:0] PC  = 32'h0040_1000;
  localparam logic [15:0] GH  = 16'hA5C3;
  localparam logic [31:0] TG  = 32'h0040_8000;

  initial begin
    clear_btb();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (busy || done || btb_rd_en || dir_upd_en || btb_touch_en || btb_ins_en) begin
      failures++;
      $display("FAIL R1 reset: actual busy=%b done=%b expected 0", busy, done);
    end

    // R4 / R2 / R3: correct walks of lengths 1, 3 and MAX
    run_commit(PC, GH, TG, 1'b1, 1, 4, 0);
    run_commit(PC, GH, TG, 1'b1, 3, 4, 0);
    run_commit(32'h1234_5678, 16'h8001, TG, 1'b1, 4, 2, 0);

    // R5 / R6: step 1 hits wrong target, step 2 matches
    clear_btb();
    put(0, vpc_of(PC, 1), 32'hDEAD_0000, 2);
    put(1, vpc_of(PC, 2), TG, 1);
    run_commit(PC, GH, TG, 1'b0, 0, 5, 0);

    // R6: miss at step 1, wrong hit at 2, match at 3
    clear_btb();
    put(0, vpc_of(PC, 2), 32'hBEEF_0000, 1);
    put(1, vpc_of(PC, 3), TG, 3);
    run_commit(PC, GH, TG, 1'b0, 0, 6, 0);

    // R7: misses at steps 2 and 4, insert at step 2
    clear_btb();
    put(0, vpc_of(PC, 1), 32'h1111_0000, 1);
    put(1, vpc_of(PC, 3), 32'h3333_0000, 0);
    run_commit(PC, GH, TG, 1'b0, 0, 7, 0);

    // R8: all wrong hits, usage 3,1,5,1 -> tie goes to step 4
    clear_btb();
    put(0, vpc_of(PC, 1), 32'h1111_0000, 3);
    put(1, vpc_of(PC, 2), 32'h2222_0000, 1);
    put(2, vpc_of(PC, 3), 32'h3333_0000, 5);
    put(3, vpc_of(PC, 4), 32'h4444_0000, 1);
    run_commit(PC, GH, TG, 1'b0, 0, 8, 0);

    // R8: usage 2,0,3,4 -> step 2
    clear_btb();
    put(0, vpc_of(PC, 1), 32'h1111_0000, 2);
    put(1, vpc_of(PC, 2), 32'h2222_0000, 0);
    put(2, vpc_of(PC, 3), 32'h3333_0000, 3);
    put(3, vpc_of(PC, 4), 32'h4444_0000, 4);
    run_commit(PC, GH, TG, 1'b0, 0, 8, 0);

    // R10: flagged correct with step 0 and step 5 -> wrong walk
    clear_btb();
    put(0, vpc_of(PC, 1), 32'hDEAD_0000, 2);
    put(1, vpc_of(PC, 2), TG, 1);
    run_commit(PC, GH, TG, 1'b1, 0, 10, 0);
    run_commit(PC, GH, TG, 1'b1, 5, 10, 0);

    // R9: request held high during the walk must be ignored
    clear_btb();
    run_commit(PC, GH, TG, 1'b1, 4, 9, 2);
    repeat (3) @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule